// File: doc/BRIEF.md
# Request-to-Flit Command Serializer

This block sits between an initiator that issues bus requests one word per beat and the command side of a packet network whose flits are 40 bits wide. For each request it emits a header flit first. The header carries the target address, and its most significant bits are the ones the network uses to route the packet to a cluster X/Y position and a local port. A second flit follows with the initiator's source identifier, the command and packet-type codes and the thread tag. Write-type requests then add one flit for each data word. A separate end-of-packet flag marks the final flit of every packet.

Both sides use valid/ready handshakes. A flit moves when `out_valid` and `out_ready` are both high at a rising clock edge. An input beat is taken when `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and all input fields steady until the beat is taken. `in_ready` is raised only in a cycle where the flit built from that beat is being accepted. Any back-pressure from the network therefore reaches the producer in the same cycle, and no flit is lost or sent twice. The block holds no flit storage: the header and info flits are both built from the beat that is being held. Reads and linked loads use a single beat with `in_last` high. A write uses 1 to 16 beats. Store-conditional and compare-and-swap use exactly two beats: the first beat carries the reservation signature or the expected old value, and the second carries the new data.

Top module: `cmd_flit_serializer`

## Requirements
- R1: The first flit of every packet has the address left-aligned in bits [39:40-ADDR_W] with zeros below it, and bit 0 (broadcast) is 0. The top NX+NY+NL bits are therefore the address MSBs.
- R2: The second flit holds the source ID left-aligned in bits [39:26], zero-padded when NX+NY+NL < 14, and the thread tag in bits [19:16]. Bits [15:0] are zero.
- R3: The second flit holds the command code in bits [25:24] and the packet type in bits [23:20], by request kind (`in_kind`: 0 READ, 1 WRITE, 2 LL, 3 SC, 4 CAS; other values are treated as READ). The codes are READ 01/0000, WRITE 10/0100, LL 11/0110, SC 00/0111, CAS 00/0101. The packet-type MSB is always 0.
- R4: READ and LL produce exactly two flits. End-of-packet is set on the second flit, and the input beat is taken with that flit.
- R5: WRITE produces a header, an info flit, and then one data flit per beat in arrival order, with the word in bits [39:8] and zeros below. End-of-packet is set on the flit from the beat with `in_last` high.
- R6: SC and CAS produce header, info and two data flits. The first data flit carries the first beat's word (signature or old value) and the second carries the new data.
- R7: `in_ready` is low in every cycle where `out_ready` is low. Under any back-pressure, the flit stream is the same as without it: no flit is dropped or repeated.
- R8: While reset is asserted and `in_valid` is low, `out_valid` and `in_ready` are low. After reset the next flit is a header.
- R9: An input beat is never taken while its header flit is being sent, and for data-carrying kinds it is not taken while the info flit is being sent either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request beat valid |
| in_ready | output | 1 | Request beat taken this cycle |
| in_addr | input | ADDR_W | Target byte address |
| in_srcid | input | NX+NY+NL | Initiator identifier |
| in_kind | input | 3 | Request kind code |
| in_trdid | input | 4 | Thread tag |
| in_wdata | input | 32 | Data word of this beat |
| in_last | input | 1 | Last beat of request |
| out_valid | output | 1 | Flit valid |
| out_ready | input | 1 | Network accepts flit |
| out_flit | output | 40 | Command flit |
| out_eop | output | 1 | Last flit of packet |

## Verification
The assertions check, on every cycle, several properties of the sequencer. Back-pressure reaches `in_ready` in the same cycle. The input is held while the header is sent. A header is always followed by the info flit, and an end-of-packet transfer returns the sequencer to the header phase. The broadcast bit of each header is also checked. The bit layout of each flit, the kind-to-code mapping, the padding of narrow fields, the order of the two atomic words and the exact count of data flits can only be shown by the bench. It compares every flit against a queue computed from the requests, both with free-flowing and with randomly stalled handshakes.

// File: rtl/cmdser_pkg.sv
package cmdser_pkg;
  localparam int FLIT_W = 40;
  localparam int SRCF_W = 14;
  localparam int DATA_W = 32;
  localparam int TRD_W  = 4;

  typedef enum logic [2:0] {
    K_READ  = 3'd0,
    K_WRITE = 3'd1,
    K_LL    = 3'd2,
    K_SC    = 3'd3,
    K_CAS   = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_INFO = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // {cmd[1:0], pktid[3:0]}
  function automatic logic [5:0] type_code(input logic [2:0] k);
    case (k)
      K_WRITE: type_code = {2'b10, 4'b0100};
      K_LL:    type_code = {2'b11, 4'b0110};
      K_SC:    type_code = {2'b00, 4'b0111};
      K_CAS:   type_code = {2'b00, 4'b0101};
      default: type_code = {2'b01, 4'b0000};
    endcase
  endfunction

  function automatic logic has_words(input logic [2:0] k);
    has_words = (k == K_WRITE) || (k == K_SC) || (k == K_CAS);
  endfunction
endpackage

// File: rtl/cmdser_fmt.sv
module cmdser_fmt
  import cmdser_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  srcid,
  input  logic [2:0]        kind,
  input  logic [TRD_W-1:0]  trdid,
  input  logic [DATA_W-1:0] wdata,
  output logic [FLIT_W-1:0] hdr_flit,
  output logic [FLIT_W-1:0] info_flit,
  output logic [FLIT_W-1:0] data_flit
);
  localparam int APAD = FLIT_W - ADDR_W;
  localparam int SPAD = SRCF_W - SRC_W;

  logic [FLIT_W-1:0] addr_al;
  logic [SRCF_W-1:0] src_al;

  generate
    if (APAD > 0) begin : g_addr_pad
      assign addr_al = {addr, {APAD{1'b0}}};
    end else begin : g_addr_full
      assign addr_al = addr[ADDR_W-1 -: FLIT_W];
    end
    if (SPAD > 0) begin : g_src_pad
      assign src_al = {srcid, {SPAD{1'b0}}};
    end else begin : g_src_full
      assign src_al = srcid[SRC_W-1 -: SRCF_W];
    end
  endgenerate

  // broadcast flag in bit 0 is always clear for commands
  assign hdr_flit  = {addr_al[FLIT_W-1:1], 1'b0};
  assign info_flit = {src_al, type_code(kind), trdid, 16'h0000};
  assign data_flit = {wdata, {(FLIT_W-DATA_W){1'b0}}};
endmodule

// File: rtl/cmdser_seq.sv
module cmdser_seq
  import cmdser_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   in_last,
  input  logic   words,
  input  logic   out_ready,
  output logic   out_valid,
  output logic   out_eop,
  output logic   in_ready,
  output phase_e phase
);
  phase_e nxt;
  logic   fire;

  assign out_valid = in_valid;
  assign fire      = in_valid && out_ready;

  always_comb begin
    in_ready = 1'b0;
    out_eop  = 1'b0;
    nxt      = phase;
    case (phase)
      PH_HDR: begin
        if (fire) nxt = PH_INFO;
      end
      PH_INFO: begin
        if (!words) begin
          in_ready = out_ready;
          out_eop  = 1'b1;
          if (fire) nxt = PH_HDR;
        end else if (fire) begin
          nxt = PH_DATA;
        end
      end
      default: begin
        in_ready = out_ready;
        out_eop  = in_last;
        if (fire && in_last) nxt = PH_HDR;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_HDR;
    else        phase <= nxt;
  end

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);
  // R9
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HDR) |-> !in_ready);
  // R4
  eop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> (phase == PH_HDR));
  // R2
  hdr_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HDR && out_valid && out_ready) |=> (phase == PH_INFO));
endmodule

// File: rtl/cmd_flit_serializer.sv
module cmd_flit_serializer
  import cmdser_pkg::*;
#(
  parameter int NX     = 4,
  parameter int NY     = 4,
  parameter int NL     = 4,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [NX+NY+NL-1:0]  in_srcid,
  input  logic [2:0]           in_kind,
  input  logic [3:0]           in_trdid,
  input  logic [31:0]          in_wdata,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [39:0]          out_flit,
  output logic                 out_eop
);
  localparam int SRC_W = NX + NY + NL;

  logic [FLIT_W-1:0] hdr_f, info_f, data_f;
  phase_e            phase;

  cmdser_fmt #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_fmt (
    .addr(in_addr), .srcid(in_srcid), .kind(in_kind), .trdid(in_trdid),
    .wdata(in_wdata), .hdr_flit(hdr_f), .info_flit(info_f), .data_flit(data_f)
  );

  cmdser_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .words(has_words(in_kind)), .out_ready(out_ready), .out_valid(out_valid),
    .out_eop(out_eop), .in_ready(in_ready), .phase(phase)
  );

  always_comb begin
    case (phase)
      PH_HDR:  out_flit = hdr_f;
      PH_INFO: out_flit = info_f;
      default: out_flit = data_f;
    endcase
  end

  // R1
  bc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && phase == PH_HDR) |-> (out_flit[0] == 1'b0));
endmodule

// File: tb/tb_cmd_flit_serializer.sv
module tb_cmd_flit_serializer;
  localparam int AW = 32;
  localparam int SW = 12;

  typedef struct {
    logic [AW-1:0] addr;
    logic [SW-1:0] src;
    logic [2:0]    kind;
    logic [3:0]    trd;
    logic [31:0]   wd;
    logic          last;
  } beat_t;

  typedef struct {
    logic [39:0] flit;
    logic        eop;
    logic        take;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready, in_last = 0;
  logic [AW-1:0] in_addr = '0;
  logic [SW-1:0] in_srcid = '0;
  logic [2:0] in_kind = '0;
  logic [3:0] in_trdid = '0;
  logic [31:0] in_wdata = '0;
  logic out_valid, out_ready = 0, out_eop;
  logic [39:0] out_flit;

  int tests = 0, fails = 0;
  beat_t beats[$];
  exp_t  expq[$];

  always #10 clk = ~clk;

  cmd_flit_serializer #(.NX(4), .NY(4), .NL(4), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_srcid(in_srcid), .in_kind(in_kind),
    .in_trdid(in_trdid), .in_wdata(in_wdata), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .out_eop(out_eop)
  );

  function automatic logic [5:0] codes(input logic [2:0] k);
    if (k == 3'd1) return 6'b10_0100;
    if (k == 3'd2) return 6'b11_0110;
    if (k == 3'd3) return 6'b00_0111;
    if (k == 3'd4) return 6'b00_0101;
    return 6'b01_0000;
  endfunction

  task automatic push_exp(input logic [39:0] f, input logic e, input logic t, input string tg);
    exp_t x;
    x.flit = f; x.eop = e; x.take = t; x.tag = tg;
    expq.push_back(x);
  endtask

  task automatic add_pkt(input logic [2:0] k, input logic [AW-1:0] a,
                         input logic [SW-1:0] s, input logic [3:0] t,
                         input int n, input logic [31:0] base);
    int nb = (n < 1) ? 1 : n;
    bit words = (k == 3'd1) || (k == 3'd3) || (k == 3'd4);
    string itag = (k == 3'd0 || k == 3'd2) ? "R4" : ((k == 3'd1) ? "R2" : "R3");
    string dtag = (k == 3'd1) ? "R5" : "R6";
    if (!words) nb = 1;
    for (int i = 0; i < nb; i++) begin
      beat_t b;
      b.addr = a + AW'(4 * i); b.src = s; b.kind = k; b.trd = t;
      b.wd = base + 32'(i * 32'h0101_0101); b.last = (i == nb - 1);
      beats.push_back(b);
    end
    // R1: header from first beat
    push_exp({a, 8'h00}, 1'b0, 1'b0, "R1");
    push_exp({s, 2'b00, codes(k), t, 16'h0}, !words, !words, itag);
    if (words)
      for (int i = 0; i < nb; i++)
        push_exp({base + 32'(i * 32'h0101_0101), 8'h00}, i == nb - 1, 1'b1, dtag);
  endtask

  task automatic run(input bit stalls, input bit gaps);
    bit took = 0;
    int wd = 0;
    while ((beats.size() > 0 || expq.size() > 0 || in_valid) && wd < 20000) begin
      @(negedge clk);
      wd++;
      if (took) begin
        void'(beats.pop_front());
        in_valid = 0;
        took = 0;
      end
      if (!in_valid && beats.size() > 0 && (!gaps || $urandom_range(0, 3) != 0)) begin
        in_addr = beats[0].addr; in_srcid = beats[0].src; in_kind = beats[0].kind;
        in_trdid = beats[0].trd; in_wdata = beats[0].wd; in_last = beats[0].last;
        in_valid = 1;
      end
      out_ready = stalls ? ($urandom_range(0, 2) != 0) : 1'b1;
      #5;
      if (out_valid) begin
        tests++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R7: extra flit %h, expected none", out_flit);
        end else if (out_flit !== expq[0].flit || out_eop !== expq[0].eop) begin
          fails++;
          $display("FAIL %s: flit %h eop %b, expected %h eop %b",
                   expq[0].tag, out_flit, out_eop, expq[0].flit, expq[0].eop);
        end
      end
      // R9 / R7: a beat is taken exactly with the flit that finishes using it
      tests++;
      if ((in_valid && in_ready) !== (out_valid && out_ready && expq.size() > 0 && expq[0].take)) begin
        fails++;
        $display("FAIL R9: in take %b, expected %b", in_valid && in_ready,
                 out_valid && out_ready && expq.size() > 0 && expq[0].take);
      end
      if (!out_ready && in_ready) begin
        tests++; fails++;
        $display("FAIL R7: in_ready 1 with out_ready 0, expected 0");
      end
      if (out_valid && out_ready && expq.size() > 0) void'(expq.pop_front());
      if (in_valid && in_ready) took = 1;
    end
    if (wd >= 20000) begin
      tests++; fails++;
      $display("FAIL R7: watchdog expired, expected stream to drain");
    end
  endtask

  task automatic load_set(input logic [31:0] salt);
    add_pkt(3'd0, 32'hFFFF_FFFC ^ salt, 12'hFFF, 4'hF, 1, 0);       // R4 read, all-ones routing
    add_pkt(3'd2, 32'h8000_0040, 12'h001, 4'h3, 1, 0);               // R4 LL
    add_pkt(3'd1, 32'h1234_5678, 12'hA5C, 4'h0, 1, 32'hDEAD_0000 ^ salt); // R5 single
    add_pkt(3'd1, 32'h0000_0100, 12'h3C3, 4'h9, 16, 32'h1111_0000);   // R5 full line
    add_pkt(3'd3, 32'h4000_0008, 12'h800, 4'h1, 2, 32'h5157_0000);    // R6 SC
    add_pkt(3'd4, 32'hC000_000C, 12'h07F, 4'h7, 2, 32'hCA50_0000);    // R6 CAS
    add_pkt(3'd7, 32'h0F0F_0F00, 12'h111, 4'h2, 1, 0);               // R3 undefined kind -> READ
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R8
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R8: valid %b ready %b, expected 0 0", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1;
    load_set(32'h0);
    run(0, 0);
    load_set(32'h0000_00F0);
    run(1, 0);           // R7 network stalls
    load_set(32'h0000_0F00);
    run(1, 1);           // R7 stalls plus input gaps
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule